// File: doc/BRIEF.md
# Time-Multiplexed HDLC Transmit Engine

This block is a single HDLC framing engine that serves every timeslot of a TDM serial highway. One line bit goes out per `bit_tick`. The position inside the highway frame comes from an internal slot and bit counter, which `frame_sync` realigns to slot 0, bit 0.

Each channel keeps its own context, held in a per-channel store. The context holds:
- the framing phase
- the bits still pending from the current octet or flag
- the count of consecutive ones
- the running CRC
- the byte index
- the ping-pong selector

The context is fetched at the first bit of a slot and written back after the eighth bit. Between those two points a working copy carries it.

Frame data sits in two alternating buffers per channel. A buffer model outside the block owns them and answers a combinational byte read. Each buffer has a status word that the engine reads and updates. The fields are go, done, end-of-frame, abort and a byte count. The engine wraps the bytes in flags, inserts zeros, appends a CRC-32 check sequence, hands buffers back and raises a sticky per-channel interrupt bit.

Top module: `tdm_hdlc_tx`

## Requirements
- R1: While reset is asserted, `tx_bit` is 1 and every `irq` bit is 0.
- R2: While `tx_en` is 0, every timeslot carries `idle_byte`, least significant bit first, and no channel state or status word changes.
- R3: A channel whose `chan_en` bit is 0 carries `idle_byte` in its timeslot while `tx_en` is 1.
- R4: A channel with no ready buffer sends back-to-back flag octets 0x7E without a break.
- R5: A buffer is ready when go=1, done=1 and count>0. Readiness is tested at the start of a frame and at the start of each buffer. The bytes of a frame go out least significant bit first, between an opening and a closing flag.
- R6: The check sequence is the reflected CRC-32 (polynomial 0xEDB88320) over the data bits, preset to all ones. Its complement follows the data, least significant bit first, so byte 0 of the sequence is bits 7:0.
- R7: A 0 is inserted after every five consecutive 1s of data or check sequence, and never inside a flag. Every `bit_tick` emits exactly one line bit, so a timeslot carries 8 line bits however much stuffing occurred.
- R8: When the last byte of a buffer is read, the engine pulses `st_clr_done` on that buffer, sets the channel's `irq` bit and switches to the other buffer. If the ending buffer had end-of-frame clear, the frame continues from the other buffer.
- R9: If a frame needs the other buffer and that buffer is not ready, the engine sends a closing flag, pulses `st_set_abort` on that buffer and sets the channel's `irq` bit. No check sequence is sent.
- R10: An `irq` bit stays set until the matching `irq_clr` bit is 1 in a clock cycle.
- R11: `st_clr_done` and `st_set_abort` pulse only in a cycle with `bit_tick` high, and never while `tx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per line bit |
| frame_sync | input | 1 | With `bit_tick`, marks slot 0 bit 0 |
| tx_en | input | 1 | Global transmit enable |
| chan_en | input | NCH | Per-channel enable |
| idle_byte | input | 8 | Byte sent in disabled slots |
| cur_ch | output | SW | Channel of the current timeslot (read and status index) |
| cur_buf | output | 1 | Active ping-pong buffer of that channel |
| rd_addr | output | AW | Byte index within the active buffer |
| rd_data | input | 8 | Buffer byte at `cur_ch`/`cur_buf`/`rd_addr` |
| stat_go | input | 1 | Go bit of the addressed status word |
| stat_done | input | 1 | Done bit of the addressed status word |
| stat_eof | input | 1 | End-of-frame bit of the addressed status word |
| stat_cnt | input | AW+1 | Byte count of the addressed status word |
| st_we | output | 1 | Status update strobe |
| st_clr_done | output | 1 | Clear done in the addressed status word |
| st_set_abort | output | 1 | Set abort in the addressed status word |
| irq | output | NCH | Sticky per-channel interrupt bits |
| irq_clr | input | NCH | Per-channel interrupt clear |
| tx_bit | output | 1 | Serial line output |

## Verification
The assertions rely on the buffer model returning, within the same cycle, the status word for the channel and buffer the block presents. They also rely on the host leaving a status word unchanged while its buffer is being sent. The bench therefore writes all buffer contents and status words before raising `tx_en`, and afterwards changes only what the block itself strobes. Channel scenarios are drawn at random with a fixed seed: lengths of 1 to 16, one or two buffers, and random data. Directed channels sit beside them, covering a one-byte frame, all-ones data, a mid-frame abort, a disabled slot and idle channels. The serial stream of each channel is de-stuffed and split at flags by an independent decoder.

// File: rtl/tdm_hdlc_tx.sv
module tdm_hdlc_tx #(
  parameter int NCH = 32,
  parameter int AW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             frame_sync,
  input  logic             tx_en,
  input  logic [NCH-1:0]   chan_en,
  input  logic [7:0]       idle_byte,
  output logic [$clog2(NCH)-1:0] cur_ch,
  output logic             cur_buf,
  output logic [AW-1:0]    rd_addr,
  input  logic [7:0]       rd_data,
  input  logic             stat_go,
  input  logic             stat_done,
  input  logic             stat_eof,
  input  logic [AW:0]      stat_cnt,
  output logic             st_we,
  output logic             st_clr_done,
  output logic             st_set_abort,
  output logic [NCH-1:0]   irq,
  input  logic [NCH-1:0]   irq_clr,
  output logic             tx_bit
);
  localparam int SW = $clog2(NCH);
  localparam int CW = AW + 1;
  localparam logic [1:0] PH_FLAG = 2'd0, PH_DATA = 2'd1, PH_FCS = 2'd2;
  localparam logic [7:0]  FLAG_OCT = 8'h7E;
  localparam logic [31:0] POLY_R = 32'hEDB88320;

  typedef struct packed {
    logic [1:0]    ph;
    logic [7:0]    sh;
    logic [5:0]    nb;
    logic [2:0]    ones;
    logic [31:0]   crc;
    logic [AW-1:0] idx;
    logic          pp;
    logic          last;
  } ctx_t;

  localparam ctx_t CTX_RST = '{ph: PH_FLAG, sh: FLAG_OCT, nb: 6'd8, ones: 3'd0,
                               crc: '1, idx: '0, pp: 1'b0, last: 1'b0};

  ctx_t ctx_mem [NCH];
  ctx_t wrk, cur, nxt;
  logic [SW-1:0] slot_q, slot;
  logic [2:0]    bit_q, bpos;
  logic          ob, ready, enb, wr_clr, wr_abt, irq_set;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
    return {1'b0, c[31:1]} ^ ((c[0] ^ b) ? POLY_R : 32'd0);
  endfunction

  assign slot  = frame_sync ? '0 : slot_q;
  assign bpos  = frame_sync ? 3'd0 : bit_q;
  assign cur   = (bpos == 3'd0) ? ctx_mem[slot] : wrk;
  assign enb   = tx_en & chan_en[slot];
  assign ready = stat_go & stat_done & (stat_cnt != '0);

  assign cur_ch       = slot;
  assign cur_buf      = cur.pp;
  assign rd_addr      = cur.idx;
  assign st_clr_done  = bit_tick & wr_clr;
  assign st_set_abort = bit_tick & wr_abt;
  assign st_we        = st_clr_done | st_set_abort;

  always_comb begin
    nxt     = cur;
    ob      = 1'b1;
    wr_clr  = 1'b0;
    wr_abt  = 1'b0;
    irq_set = 1'b0;
    if (!enb) begin
      ob = idle_byte[bpos];
    end else if (cur.ones == 3'd5) begin
      ob       = 1'b0;
      nxt.ones = 3'd0;
    end else begin
      if (cur.ph == PH_FCS) begin
        ob      = ~cur.crc[0];
        nxt.crc = {1'b0, cur.crc[31:1]};
      end else begin
        ob     = cur.sh[0];
        nxt.sh = {1'b0, cur.sh[7:1]};
      end
      nxt.nb = cur.nb - 6'd1;
      if (cur.ph == PH_FLAG) nxt.ones = 3'd0;
      else                   nxt.ones = ob ? cur.ones + 3'd1 : 3'd0;
      if (cur.ph == PH_DATA) nxt.crc = crc_step(cur.crc, ob);
      if (cur.nb == 6'd1) begin
        if (cur.ph == PH_FCS) begin
          nxt.ph = PH_FLAG;
          nxt.sh = FLAG_OCT;
          nxt.nb = 6'd8;
        end else if (cur.ph == PH_DATA && cur.last) begin
          nxt.ph   = PH_FCS;
          nxt.nb   = 6'd32;
          nxt.last = 1'b0;
        end else if (ready || (cur.ph == PH_DATA && cur.idx != '0)) begin
          if (cur.ph == PH_FLAG) nxt.crc = '1;
          nxt.ph = PH_DATA;
          nxt.sh = rd_data;
          nxt.nb = 6'd8;
          if (CW'(cur.idx) + CW'(1) == stat_cnt) begin
            nxt.idx  = '0;
            nxt.pp   = ~cur.pp;
            nxt.last = stat_eof;
            wr_clr   = 1'b1;
            irq_set  = 1'b1;
          end else begin
            nxt.idx = cur.idx + AW'(1);
          end
        end else begin
          nxt.ph = PH_FLAG;
          nxt.sh = FLAG_OCT;
          nxt.nb = 6'd8;
          if (cur.ph == PH_DATA) begin
            wr_abt  = 1'b1;
            irq_set = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      bit_q  <= '0;
      tx_bit <= 1'b1;
      irq    <= '0;
      wrk    <= CTX_RST;
      for (int i = 0; i < NCH; i++) ctx_mem[i] <= CTX_RST;
    end else begin
      irq <= (irq & ~irq_clr) | ((bit_tick & irq_set) ? (NCH'(1) << slot) : '0);
      if (bit_tick) begin
        tx_bit <= ob;
        bit_q  <= bpos + 3'd1;
        if (bpos == 3'd7) begin
          ctx_mem[slot] <= nxt;
          slot_q <= (slot == SW'(NCH - 1)) ? '0 : slot + SW'(1);
        end else begin
          slot_q <= slot;
          wrk    <= nxt;
        end
      end
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_bit)); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq) & ~$past(irq_clr)) & ~irq) == '0)); // R10
  AST_WR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> bit_tick); // R11
  AST_NO_WR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !st_we); // R2
  AST_LAST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    st_clr_done |-> (CW'(rd_addr) + CW'(1) == stat_cnt)); // R8
  AST_ABORT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    st_set_abort |-> !(stat_go && stat_done && stat_cnt != '0)); // R9
  AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_clr_done, st_set_abort})); // R8
endmodule

// File: tb/tdm_hdlc_tx_test.sv
module tdm_hdlc_tx_test;
  localparam int NCH = 32, AW = 4, CW = AW + 1, SW = 5;
  localparam int MAXB = 560, ENF = 66, NFR = 16;

  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, frame_sync = 1'b0, tx_en = 1'b0;
  logic [NCH-1:0] chan_en = '1, irq_clr = '0;
  logic [7:0] idle_byte = 8'h00;
  logic [SW-1:0] cur_ch;
  logic cur_buf, stat_go, stat_done, stat_eof, st_we, st_clr_done, st_set_abort, tx_bit;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data;
  logic [CW-1:0] stat_cnt;
  logic [NCH-1:0] irq;

  logic [7:0]    mem   [NCH][2][16];
  logic          s_go  [NCH][2];
  logic          s_done[NCH][2];
  logic          s_eof [NCH][2];
  logic          s_abt [NCH][2];
  logic [CW-1:0] s_cnt [NCH][2];
  logic [7:0]    expb  [NCH][40];
  int            explen[NCH];
  logic          cap   [NCH][MAXB];
  int            ncap  [NCH];
  logic          fbits [MAXB];
  logic [7:0]    frb   [NCH][48];
  int            frlen [NCH], frcnt[NCH], viol[NCH];
  int checks = 0, fails = 0, badwr = 0;
  logic fin = 1'b0;

  always #4 clk = ~clk;

  tdm_hdlc_tx #(.NCH(NCH), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_sync(frame_sync),
    .tx_en(tx_en), .chan_en(chan_en), .idle_byte(idle_byte),
    .cur_ch(cur_ch), .cur_buf(cur_buf), .rd_addr(rd_addr), .rd_data(rd_data),
    .stat_go(stat_go), .stat_done(stat_done), .stat_eof(stat_eof), .stat_cnt(stat_cnt),
    .st_we(st_we), .st_clr_done(st_clr_done), .st_set_abort(st_set_abort),
    .irq(irq), .irq_clr(irq_clr), .tx_bit(tx_bit));

  assign rd_data   = mem[cur_ch][cur_buf][rd_addr];
  assign stat_go   = s_go[cur_ch][cur_buf];
  assign stat_done = s_done[cur_ch][cur_buf];
  assign stat_eof  = s_eof[cur_ch][cur_buf];
  assign stat_cnt  = s_cnt[cur_ch][cur_buf];

  always @(posedge clk) begin
    if (st_we && !bit_tick) badwr++;
    if (st_we && !tx_en) badwr++;
    if (st_clr_done)  s_done[cur_ch][cur_buf] <= 1'b0;
    if (st_set_abort) s_abt[cur_ch][cur_buf]  <= 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fcs_of(input int ch, input int n);
    logic [31:0] c = '1;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++)
        c = {1'b0, c[31:1]} ^ ((c[0] ^ expb[ch][k][j]) ? 32'hEDB88320 : 32'd0);
    return ~c;
  endfunction

  task automatic setup(input int ch, input int l0, input int l1, input bit ff, input bit abort);
    int n = 0;
    for (int b = 0; b < 2; b++) begin
      int l = (b == 0) ? l0 : l1;
      if (l > 0) begin
        for (int k = 0; k < l; k++) begin
          mem[ch][b][k] = ff ? 8'hFF : 8'($urandom);
          expb[ch][n++] = mem[ch][b][k];
        end
        s_go[ch][b] = 1'b1; s_done[ch][b] = 1'b1; s_cnt[ch][b] = CW'(l);
        s_eof[ch][b] = !abort && (b == 1 || l1 == 0);
      end
    end
    if (!abort) begin
      logic [31:0] f = fcs_of(ch, n);
      for (int k = 0; k < 4; k++) expb[ch][n++] = f[8*k +: 8];
    end
    explen[ch] = n;
  endtask

  task automatic decode(input int ch);
    int ones = 0, nb = 0;
    bit sync = 0;
    frcnt[ch] = 0; frlen[ch] = -1; viol[ch] = 0;
    for (int i = 0; i < ncap[ch]; i++) begin
      if (cap[ch][i]) begin
        ones++;
        if (ones > 6) viol[ch]++;
        fbits[nb++] = 1'b1;
      end else if (ones == 5) begin
        ones = 0;
      end else if (ones == 6) begin
        nb -= 7;
        if (sync && nb > 0) begin
          if (frcnt[ch] == 0) begin
            frlen[ch] = (nb % 8 == 0 && nb / 8 <= 48) ? nb / 8 : -2;
            if (frlen[ch] > 0)
              for (int k = 0; k < frlen[ch]; k++)
                for (int j = 0; j < 8; j++) frb[ch][k][j] = fbits[8*k + j];
          end
          frcnt[ch]++;
        end
        sync = 1; nb = 0; ones = 0;
      end else begin
        ones = 0;
        fbits[nb++] = 1'b0;
      end
      if (nb >= MAXB) nb = 0;
    end
  endtask

  task automatic step(input bit fs, output logic b);
    @(negedge clk); bit_tick = 1'b1; frame_sync = fs;
    @(negedge clk); bit_tick = 1'b0; frame_sync = 1'b0; b = tx_bit;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int mism2 = 0, mism3 = 0, mism4 = 0;
    logic b;
    logic [7:0] oct;
    void'($urandom(32'd2024));
    for (int c = 0; c < NCH; c++) begin
      for (int b2 = 0; b2 < 2; b2++) begin
        s_go[c][b2] = 0; s_done[c][b2] = 0; s_eof[c][b2] = 0; s_abt[c][b2] = 0; s_cnt[c][b2] = '0;
        for (int k = 0; k < 16; k++) mem[c][b2][k] = 8'h00;
      end
      explen[c] = 0; ncap[c] = 0;
    end
    idle_byte = 8'hA5;
    repeat (3) @(negedge clk);
    chk(tx_bit === 1'b1, "R1 line idle in reset", int'(tx_bit), 1);
    chk(irq === '0, "R1 irq clear in reset", int'(irq), 0);
    rst_n = 1'b1;

    setup(2, $urandom_range(2, 16), 0, 0, 0);
    setup(3, $urandom_range(1, 16), $urandom_range(1, 16), 0, 0);
    setup(4, $urandom_range(1, 16), 0, 0, 1);
    setup(5, 16, 0, 1, 0);
    setup(6, 1, 0, 0, 0);
    for (int c = 7; c < NFR; c++)
      setup(c, $urandom_range(1, 16), ($urandom % 2) ? $urandom_range(1, 16) : 0, 0, 0);
    s_go[1][0] = 1; s_done[1][0] = 1; s_cnt[1][0] = 5'd3; s_eof[1][0] = 1;
    chan_en[1] = 1'b0;

    for (int f = 0; f < 2; f++)
      for (int s = 0; s < NCH; s++) begin
        for (int bp = 0; bp < 8; bp++) begin step(s == 0 && bp == 0, b); oct[bp] = b; end
        if (oct !== idle_byte) mism2++;
      end
    chk(mism2 == 0, "R2 idle byte while globally off", mism2, 0);
    chk(s_done[2][0] === 1'b1, "R2 no status change while off", int'(s_done[2][0]), 1);

    tx_en = 1'b1;
    for (int f = 0; f < ENF; f++)
      for (int s = 0; s < NCH; s++) begin
        for (int bp = 0; bp < 8; bp++) begin
          step(s == 0 && bp == 0, b); oct[bp] = b;
          cap[s][ncap[s]++] = b;
        end
        if (s == 1 && oct !== idle_byte) mism3++;
        if ((s == 0 || s >= NFR) && oct !== 8'h7E) mism4++;
      end
    chk(mism3 == 0, "R3 disabled slot carries idle byte", mism3, 0);
    chk(mism4 == 0, "R4 back-to-back flags without data", mism4, 0);
    chk(s_done[1][0] === 1'b1, "R3 disabled channel leaves buffer", int'(s_done[1][0]), 1);

    for (int c = 0; c < NCH; c++) decode(c);
    for (int c = 0; c < NCH; c++) chk(viol[c] == 0, $sformatf("R7 run of ones ch%0d", c), viol[c], 0);
    for (int c = 2; c < NFR; c++) begin
      int bad = 0;
      chk(frcnt[c] == 1, $sformatf("R5 frame count ch%0d", c), frcnt[c], 1);
      chk(frlen[c] == explen[c], $sformatf("R5 frame length ch%0d", c), frlen[c], explen[c]);
      if (frlen[c] == explen[c])
        for (int k = 0; k < explen[c]; k++) if (frb[c][k] !== expb[c][k]) bad++;
      chk(bad == 0, $sformatf("R6 frame bytes and check sequence ch%0d", c), bad, 0);
    end
    chk(frcnt[0] == 0, "R4 no frame on idle channel", frcnt[0], 0);
    chk(frlen[5] == 20, "R7 stuffed all-ones frame length", frlen[5], 20);

    for (int c = 2; c < NFR; c++) begin
      if (c == 4) continue;
      chk(irq[c] === 1'b1, $sformatf("R8 irq after buffer ch%0d", c), int'(irq[c]), 1);
      chk(s_done[c][0] === 1'b0, $sformatf("R8 done cleared ch%0d", c), int'(s_done[c][0]), 0);
      if (s_cnt[c][1] != 0)
        chk(s_done[c][1] === 1'b0, $sformatf("R8 second buffer done ch%0d", c), int'(s_done[c][1]), 0);
    end
    chk(s_abt[4][1] === 1'b1, "R9 abort flagged on unready buffer", int'(s_abt[4][1]), 1);
    chk(s_abt[4][0] === 1'b0, "R9 finished buffer not aborted", int'(s_abt[4][0]), 0);
    chk(irq[4] === 1'b1, "R9 irq on abort", int'(irq[4]), 1);
    chk(s_done[4][0] === 1'b0, "R9 first buffer handed back", int'(s_done[4][0]), 0);
    chk(irq[0] === 1'b0, "R10 idle channel has no irq", int'(irq[0]), 0);

    repeat (5) @(negedge clk);
    chk(irq[2] === 1'b1, "R10 irq held without clear", int'(irq[2]), 1);
    irq_clr = irq;
    @(negedge clk); irq_clr = '0;
    @(negedge clk);
    chk(irq === '0, "R10 irq cleared", int'(irq), 0);
    chk(badwr == 0, "R11 status strobes only on ticks", badwr, 0);

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule